// File: doc/BRIEF.md
# Key-Armed Machine-Cycle Watchdog

The block is a supervisory counter that recovers a processor from a software upset. It stays dormant after reset. Software arms it by writing a two-byte key, 0x1E and then 0xE1, to a write-only service port. Once armed, a 14-bit count advances on each machine-cycle tick. Software must write the same key pair again before the count reaches its top value. Software has no way to disarm the block. Only an external reset, or the block's own overflow, returns it to the dormant state.

On overflow the block raises a one-clock reset request toward the reset controller. It can also drive the device reset pin high for a fixed number of oscillator clocks. A configuration bit turns this pin drive off, so that the pin stays an input. Two low-power states affect the count:
- **Idle:** the count keeps running unless an idle-halt bit is set.
- **Power-down:** the count freezes. After power-down ends, counting stays held until the wake interrupt line returns high.

Top module: `keyed_watchdog`

## Requirements
- R1: After the asynchronous reset is released the block is dormant. With `mc_tick` held high and no valid key pair written, `rst_req_o` and `rst_out_drive` stay 0 for at least 17000 cycles. Both outputs are 0 while `rst_n` is low.
- R2: Writes on the service port arm the block only as an adjacent pair: a write of 0x1E followed directly by a write of 0xE1. Any other write after 0x1E cancels the pending first byte. A lone 0xE1 has no effect. A repeated 0x1E keeps the pending byte, so 0x1E, 0x1E, 0xE1 arms the block.
- R3: While armed, the count rises by one on each clock edge at which `mc_tick` is 1 and no halt applies. The count starts from zero at the edge that accepts 0xE1. `rst_req_o` goes high one cycle after the edge of the 16383rd counted tick, which is the tick that takes the count to 0x3FFF. Cycles with `mc_tick` at 0 are not counted.
- R4: A key pair written while the block is armed restarts the count from zero. Any other write neither restarts nor disarms the block.
- R5: `rst_req_o` is high for exactly one cycle per overflow. The overflow leaves the block dormant until the next key pair.
- R6: When `rsto_disable` is 0 at the overflow edge, `rst_out_drive` is high for exactly 98 clock cycles, starting in the cycle in which `rst_req_o` is high. When `rsto_disable` is 1 at that edge, `rst_out_drive` stays 0.
- R7: When `idle_i` is 1 and `idle_halt` is 0, counting continues. When `idle_i` is 1 and `idle_halt` is 1, the count holds, and it resumes when either input returns to 0.
- R8: While `pdown_i` is 1 the count holds. After `pdown_i` falls, the count stays held until `wake_i` is 1. Counting resumes at the first edge at which `wake_i` is 1.
- R9: An external reset returns the block to dormant, clears the count, and ends any reset-pin pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| svc_wr | input | 1 | Write strobe for the service port |
| svc_wdata | input | 8 | Byte written to the service port |
| idle_i | input | 1 | Processor is in idle |
| pdown_i | input | 1 | Processor is in power-down |
| wake_i | input | 1 | Level of the interrupt line used to leave power-down |
| rsto_disable | input | 1 | 1 keeps the reset pin input-only on overflow |
| idle_halt | input | 1 | 1 freezes the count during idle |
| rst_req_o | output | 1 | One-cycle reset request on overflow |
| rst_out_drive | output | 1 | Drives the reset pin high during the stretched pulse |

## Verification
The key decoder is driven with several write streams:
- broken pairs, a lone second byte and an intervening byte, which separate an adjacency check from a check that only looks at the data values;
- a doubled first byte, which shows whether a repeated first byte keeps the pending state.

The overflow cycle is measured exactly under three stimuli:
- continuous ticks;
- a window with the tick held low;
- restarts and junk writes placed in the middle of a count, which show whether a junk write restarts the count.

Idle with and without the halt bit shows whether the count halts or runs. Power-down followed by a late wake line shows whether counting resumes when power-down ends or only when the wake line rises. The pulse width and its cancellation by reset, with the pin drive enabled and disabled, cover the reset outputs.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned KWD_CNT_W     = 14;
  localparam int unsigned KWD_PULSE_LEN = 98;
  localparam logic [7:0]  KWD_KEY_A     = 8'h1E;
  localparam logic [7:0]  KWD_KEY_B     = 8'hE1;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
#(
  parameter logic [7:0] KEY_A = KWD_KEY_A,
  parameter logic [7:0] KEY_B = KWD_KEY_B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       key_fire
);
  logic pend_q, pend_d;

  // A first byte arms the pending flag. Any other write clears it, and the
  // second byte fires only when it lands right after the first.
  always_comb begin
    pend_d   = pend_q;
    key_fire = 1'b0;
    if (wr_en) begin
      if (wdata == KEY_A) begin
        pend_d = 1'b1;
      end else begin
        pend_d = 1'b0;
        if (pend_q && (wdata == KEY_B)) key_fire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assert_lone_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == KEY_B && !pend_q) |-> !key_fire);
endmodule

// File: rtl/kwd_count_core.sv
module kwd_count_core
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W = KWD_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic key_fire,
  input  logic idle_i,
  input  logic idle_halt,
  input  logic pdown_i,
  input  logic wake_i,
  output logic ovf_evt,
  output logic ovf_req
);
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             hold_q, hold_d;
  logic             req_q;
  logic             run;

  // Power-down hold: set during power-down, released by the wake line.
  always_comb begin
    hold_d = hold_q;
    if (pdown_i)     hold_d = 1'b1;
    else if (wake_i) hold_d = 1'b0;
  end

  assign run = armed_q & tick & ~pdown_i & ~(hold_q & ~wake_i)
             & ~(idle_i & idle_halt);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    ovf_evt = 1'b0;
    if (key_fire) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        armed_d = 1'b0;
        ovf_evt = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      hold_q  <= hold_d;
      req_q   <= ovf_evt;
    end
  end

  assign ovf_req = req_q;

  assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_req |=> !ovf_req);
  assert_key_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_fire |=> (armed_q && cnt_q == '0));
  assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && idle_halt && !key_fire) |=> $stable(cnt_q));
  assert_pdown_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_i && !key_fire) |=> $stable(cnt_q));
  assert_ovf_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_req |-> !armed_q);
endmodule

// File: rtl/kwd_pulse_stretch.sv
module kwd_pulse_stretch
  import kwd_pkg::*;
#(
  parameter int unsigned PULSE_LEN = KWD_PULSE_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic suppress,
  output logic drive
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (start && !suppress)  left_d = PW'(PULSE_LEN);
    else if (left_q != '0)   left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign drive = (left_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W     = KWD_CNT_W,
  parameter int unsigned PULSE_LEN = KWD_PULSE_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       svc_wr,
  input  logic [7:0] svc_wdata,
  input  logic       idle_i,
  input  logic       pdown_i,
  input  logic       wake_i,
  input  logic       rsto_disable,
  input  logic       idle_halt,
  output logic       rst_req_o,
  output logic       rst_out_drive
);
  logic key_fire;
  logic ovf_evt;

  kwd_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (svc_wr),
    .wdata    (svc_wdata),
    .key_fire (key_fire)
  );

  kwd_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (mc_tick),
    .key_fire  (key_fire),
    .idle_i    (idle_i),
    .idle_halt (idle_halt),
    .pdown_i   (pdown_i),
    .wake_i    (wake_i),
    .ovf_evt   (ovf_evt),
    .ovf_req   (rst_req_o)
  );

  kwd_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ovf_evt),
    .suppress (rsto_disable),
    .drive    (rst_out_drive)
  );

  assert_pulse_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_drive) |-> rst_req_o);
  assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_req_o) && $past(rsto_disable)) |-> !rst_out_drive);
endmodule

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;
  localparam int TOP = 16383;
  localparam int PULSE = 98;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_tick, svc_wr, idle_i, pdown_i, wake_i, rsto_disable, idle_halt;
  logic [7:0] svc_wdata;
  logic       rst_req_o, rst_out_drive;

  int n_chk = 0;
  int n_bad = 0;
  int seen;

  always #10 clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .svc_wr(svc_wr),
    .svc_wdata(svc_wdata), .idle_i(idle_i), .pdown_i(pdown_i),
    .wake_i(wake_i), .rsto_disable(rsto_disable), .idle_halt(idle_halt),
    .rst_req_o(rst_req_o), .rst_out_drive(rst_out_drive)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mc_tick = 1'b1; svc_wr = 1'b0; svc_wdata = 8'h00;
    idle_i = 1'b0; pdown_i = 1'b0; wake_i = 1'b1; rsto_disable = 1'b0;
    idle_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk(rst_req_o == 1'b0 && rst_out_drive == 1'b0, "R1/R9 outputs low in reset",
        {rst_req_o, rst_out_drive}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wr_byte(logic [7:0] b);
    svc_wr = 1'b1; svc_wdata = b;
    @(negedge clk);
    svc_wr = 1'b0;
    seen++;
  endtask

  task automatic key_pair();
    wr_byte(8'h1E);
    wr_byte(8'hE1);
    seen = 0;
  endtask

  // Runs n cycles and reports any reset request in between.
  task automatic step(int n, string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen++;
      if (rst_req_o || rst_out_drive) hits++;
    end
    chk(hits == 0, tag, hits, 0);
  endtask

  task automatic wait_req(int exp, string tag);
    bit got = 0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      seen++;
      if (rst_req_o) got = 1;
    end
    chk(got && seen == exp, tag, got ? seen : -1, exp);
  endtask

  // Called in the cycle where rst_req_o is high.
  task automatic check_pulse(bit expect_drive);
    int w = 0;
    int extra = 0;
    if (rst_out_drive) w = 1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (rst_req_o) extra++;
      if (rst_out_drive) w++;
    end
    chk(extra == 0, "R5 request lasts one cycle", extra, 0);
    chk(w == (expect_drive ? PULSE : 0), "R6 reset pin pulse width", w,
        expect_drive ? PULSE : 0);
  endtask

  task automatic t_sequence();
    do_reset();
    seen = 0;
    wr_byte(8'h1E); wr_byte(8'h00); wr_byte(8'hE1);
    wr_byte(8'hE1);
    wr_byte(8'h1E); wr_byte(8'h55); wr_byte(8'hE1);
    step(17000, "R1/R2 dormant after reset and broken pairs");
    wr_byte(8'h1E);
    key_pair();
    wait_req(TOP, "R2/R3 doubled first byte arms, overflow cycle");
    check_pulse(1'b1);
    wr_byte(8'h00);
    step(17000, "R5 dormant after overflow");
  endtask

  task automatic t_restart();
    do_reset();
    rsto_disable = 1'b1;
    key_pair();
    step(10000, "R4 no overflow before service");
    key_pair();
    step(2000, "R4 counting after restart");
    mc_tick = 1'b0;
    step(1000, "R3 tick low window");
    mc_tick = 1'b1;
    wr_byte(8'h00); wr_byte(8'h1E); wr_byte(8'hAA); wr_byte(8'hE1);
    wait_req(TOP + 1000, "R3/R4 junk writes keep count, tick gating");
    check_pulse(1'b0);
  endtask

  task automatic t_idle();
    do_reset();
    key_pair();
    idle_i = 1'b1; idle_halt = 1'b0;
    step(3000, "R7 idle without halt counts");
    idle_halt = 1'b1;
    step(4000, "R7 idle with halt");
    idle_i = 1'b0;
    wait_req(TOP + 4000, "R7 overflow cycle with idle halt window");
    repeat (10) @(negedge clk);
    chk(rst_out_drive == 1'b1, "R6 pulse active mid-way", rst_out_drive, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rst_out_drive == 1'b0, "R9 reset ends pulse", rst_out_drive, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rst_out_drive == 1'b0, "R9 pulse stays off after reset", rst_out_drive, 0);
    key_pair();
    step(8000, "R9 armed before reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(17000, "R9 reset disarms");
  endtask

  task automatic t_pdown();
    do_reset();
    key_pair();
    step(100, "R8 counting before power-down");
    pdown_i = 1'b1; wake_i = 1'b0;
    step(500, "R8 power-down");
    pdown_i = 1'b0;
    step(300, "R8 held until wake line high");
    wake_i = 1'b1;
    wait_req(TOP + 800, "R8 overflow cycle after power-down");
  endtask

  initial begin
    t_sequence();
    t_restart();
    t_idle();
    t_pdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 195000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule